// File: doc/BRIEF.md
# GPIO Pin Control and Multiplexer Bank

This block is the control plane for one bank of general-purpose pins. Each pin is owned either by the GPIO logic or by one of four peripheral functions. For a GPIO-owned pin, the bank holds the direction and level. For every pin it holds the pull-up and pull-down choice, open-drain mode and a Schmitt-trigger disable.

Software programs the bank through a small word-addressed register bus. Every per-pin control bit sits behind a pair of registers, one that sets bits and one that clears them, so one pin can change without a read-modify-write. Each pair has a status register alongside it that reads the current state back. The two select registers and the Schmitt register are written directly.

The pad side gets output enable, output value, pull controls, a Schmitt disable and a 2-bit peripheral select per pin. Pad inputs are synchronized and can be read back at all times.

Top module: `pin_ctrl_bank`

## Requirements
- R1: After reset every pin is GPIO-owned and is an input with output value 0. Its pull-up is on, its pull-down and open-drain are off, its select code is 00 and its Schmitt disable is 0.
- R2: A write to a set register (word address 3g) sets each state bit whose data bit is 1 and leaves bits written 0 unchanged. The groups g are 0 ownership, 1 output enable, 2 output value, 3 pull-up, 4 pull-down and 5 open-drain. The change is visible in the next cycle.
- R3: A write to a clear register (word address 3g+1) clears each state bit whose data bit is 1 and leaves bits written 0 unchanged.
- R4: Address 18 holds the low select bit of pin n at bit n, and address 19 holds the high bit. `periph_sel[2n+1:2n]` equals {high, low}. Code 00 picks function A, 01 B, 10 C and 11 D. Function f of pin n is bit f*32+n of `fn_oe`/`fn_out`.
- R5: A GPIO-owned pin (ownership bit 1) takes its pad output enable and value from the output-enable and output-value state. A pin that is not GPIO-owned takes them from the selected function.
- R6: With open-drain on, a pin drives 0 wherever the raw driver would enable a 0. It is released (output enable 0) wherever the raw driver would drive 1, and `pad_out` is 0.
- R7: Enabling the pull-down on a pin clears its pull-up in the same cycle, and the reverse also holds, so `pad_pu & pad_pd` is always 0.
- R8: The pin data register (address 21) returns `pad_in` as it stood two rising clock edges earlier, whatever the pin's ownership.
- R9: Status registers (address 3g+2) read back the state of group g. Writes to them, and to address 21, change no state.
- R10: The Schmitt register (address 20) is read/write. A 1 at bit n drives `pad_schmitt_dis[n]` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data / pin mask |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pad input levels |
| fn_oe | input | 128 | Output enables of functions A..D, 32 bits each |
| fn_out | input | 128 | Output values of functions A..D, 32 bits each |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad output value |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |
| pad_schmitt_dis | output | 32 | Schmitt-trigger disable |
| periph_sel | output | 64 | 2-bit function select per pin |

## Verification
Set and clear masks are tried with sparse, dense and single-bit patterns. These show whether bits written 0 really stay untouched. Some pins are moved to peripheral ownership with a select pattern that puts all four codes on adjacent pins, while each function drives a distinct enable/value pattern. A wrong select index or swapped select bits then shows up on a specific pin. Open-drain is applied on pins driving both 0 and 1, under both GPIO and peripheral ownership. Alternating pull-down and pull-up enables test the mutual exclusion. A pad input change is read back at 0, 1 and 2 edges afterward to pin down the synchronizer latency.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
  // control groups; group g occupies word addresses 3g (set), 3g+1 (clear), 3g+2 (status)
  localparam int GRP_OWN = 0;
  localparam int GRP_OE  = 1;
  localparam int GRP_OUT = 2;
  localparam int GRP_PU  = 3;
  localparam int GRP_PD  = 4;
  localparam int GRP_OD  = 5;
  localparam int NUM_GRP = 6;

  localparam int REG_SEL_LO   = 18;
  localparam int REG_SEL_HI   = 19;
  localparam int REG_SCHMITT  = 20;
  localparam int REG_PIN_DATA = 21;

  localparam int NUM_FN = 4;

  function automatic int set_addr(int g);
    return 3 * g;
  endfunction

  function automatic int clr_addr(int g);
    return 3 * g + 1;
  endfunction

  function automatic int stat_addr(int g);
    return 3 * g + 2;
  endfunction

  typedef struct packed {
    logic oe;
    logic val;
  } drive_t;

  // pick the raw driver by ownership, then apply open-drain
  function automatic drive_t pin_drive(logic gpio, logic g_oe, logic g_val, logic od,
                                       logic [1:0] sel, logic [NUM_FN-1:0] f_oe,
                                       logic [NUM_FN-1:0] f_val);
    drive_t raw;
    drive_t res;
    raw.oe  = gpio ? g_oe  : f_oe[sel];
    raw.val = gpio ? g_val : f_val[sel];
    if (od) begin
      res.oe  = raw.oe & ~raw.val;
      res.val = 1'b0;
    end else begin
      res = raw;
    end
    return res;
  endfunction
endpackage

// File: rtl/pin_setclr_reg.sv
module pin_setclr_reg #(
  parameter int W        = 32,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pin_pad_mux.sv
module pin_pad_mux
  import pin_ctrl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]        gpio_own,
  input  logic [N-1:0]        g_oe,
  input  logic [N-1:0]        g_val,
  input  logic [N-1:0]        od_en,
  input  logic [N-1:0]        sel_lo,
  input  logic [N-1:0]        sel_hi,
  input  logic [NUM_FN*N-1:0] fn_oe,
  input  logic [NUM_FN*N-1:0] fn_out,
  output logic [N-1:0]        pad_oe,
  output logic [N-1:0]        pad_out,
  output logic [2*N-1:0]      periph_sel
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [NUM_FN-1:0] f_oe;
    logic [NUM_FN-1:0] f_val;
    logic [1:0]        sel;
    drive_t            drv;

    for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
      assign f_oe[f]  = fn_oe[f*N + i];
      assign f_val[f] = fn_out[f*N + i];
    end

    assign sel     = {sel_hi[i], sel_lo[i]};
    assign drv     = pin_drive(gpio_own[i], g_oe[i], g_val[i], od_en[i], sel, f_oe, f_val);
    assign pad_oe[i]            = drv.oe;
    assign pad_out[i]           = drv.val;
    assign periph_sel[2*i +: 2] = sel;
  end
endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
  import pin_ctrl_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [NUM_PINS-1:0]      bus_wdata,
  output logic [NUM_PINS-1:0]      bus_rdata,
  input  logic [NUM_PINS-1:0]      pad_in,
  input  logic [NUM_FN*NUM_PINS-1:0] fn_oe,
  input  logic [NUM_FN*NUM_PINS-1:0] fn_out,
  output logic [NUM_PINS-1:0]      pad_oe,
  output logic [NUM_PINS-1:0]      pad_out,
  output logic [NUM_PINS-1:0]      pad_pu,
  output logic [NUM_PINS-1:0]      pad_pd,
  output logic [NUM_PINS-1:0]      pad_schmitt_dis,
  output logic [2*NUM_PINS-1:0]    periph_sel
);
  localparam logic [ADDR_W-1:0] A_SEL_LO  = ADDR_W'(REG_SEL_LO);
  localparam logic [ADDR_W-1:0] A_SEL_HI  = ADDR_W'(REG_SEL_HI);
  localparam logic [ADDR_W-1:0] A_SCHMITT = ADDR_W'(REG_SCHMITT);
  localparam logic [ADDR_W-1:0] A_DATA    = ADDR_W'(REG_PIN_DATA);

  logic [NUM_PINS-1:0] ctl_q    [NUM_GRP];
  logic [NUM_PINS-1:0] set_mask [NUM_GRP];
  logic [NUM_PINS-1:0] clr_req  [NUM_GRP];
  logic [NUM_PINS-1:0] clr_mask [NUM_GRP];

  // named views of the state for the checker
  logic [NUM_PINS-1:0] own_q, oe_q, out_q, pu_q, pd_q, od_q;
  logic [NUM_PINS-1:0] sel_lo_q, sel_hi_q, schmitt_q, pin_data;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_ctl
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(set_addr(g));
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(clr_addr(g));
    localparam bit ONES = (g == GRP_OWN) || (g == GRP_PU);

    assign set_mask[g] = (bus_we && bus_addr == A_SET) ? bus_wdata : '0;
    assign clr_req[g]  = (bus_we && bus_addr == A_CLR) ? bus_wdata : '0;

    // pull-up and pull-down exclude each other
    if (g == GRP_PU) begin : g_pu
      assign clr_mask[g] = clr_req[g] | set_mask[GRP_PD];
    end else if (g == GRP_PD) begin : g_pd
      assign clr_mask[g] = clr_req[g] | set_mask[GRP_PU];
    end else begin : g_plain
      assign clr_mask[g] = clr_req[g];
    end

    pin_setclr_reg #(.W(NUM_PINS), .RST_ONES(ONES)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask[g]),
      .clr_mask (clr_mask[g]),
      .q        (ctl_q[g])
    );
  end

  assign own_q = ctl_q[GRP_OWN];
  assign oe_q  = ctl_q[GRP_OE];
  assign out_q = ctl_q[GRP_OUT];
  assign pu_q  = ctl_q[GRP_PU];
  assign pd_q  = ctl_q[GRP_PD];
  assign od_q  = ctl_q[GRP_OD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo_q  <= '0;
      sel_hi_q  <= '0;
      schmitt_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_SEL_LO)  sel_lo_q  <= bus_wdata;
      if (bus_addr == A_SEL_HI)  sel_hi_q  <= bus_wdata;
      if (bus_addr == A_SCHMITT) schmitt_q <= bus_wdata;
    end
  end

  pin_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_data)
  );

  pin_pad_mux #(.N(NUM_PINS)) u_mux (
    .gpio_own   (own_q),
    .g_oe       (oe_q),
    .g_val      (out_q),
    .od_en      (od_q),
    .sel_lo     (sel_lo_q),
    .sel_hi     (sel_hi_q),
    .fn_oe      (fn_oe),
    .fn_out     (fn_out),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .periph_sel (periph_sel)
  );

  assign pad_pu          = pu_q;
  assign pad_pd          = pd_q;
  assign pad_schmitt_dis = schmitt_q;

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_addr == ADDR_W'(stat_addr(g))) bus_rdata = ctl_q[g];
    end
    if (bus_addr == A_SEL_LO)  bus_rdata = sel_lo_q;
    if (bus_addr == A_SEL_HI)  bus_rdata = sel_hi_q;
    if (bus_addr == A_SCHMITT) bus_rdata = schmitt_q;
    if (bus_addr == A_DATA)    bus_rdata = pin_data;
  end
endmodule

// File: rtl/pin_ctrl_bank_chk.sv
module pin_ctrl_bank_chk
  import pin_ctrl_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_pu,
  input logic [NUM_PINS-1:0] pad_pd,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] oe_q,
  input logic [NUM_PINS-1:0] own_q,
  input logic [NUM_PINS-1:0] od_q,
  input logic [NUM_PINS-1:0] pin_data
);
  localparam logic [ADDR_W-1:0] A_OE_SET  = ADDR_W'(set_addr(GRP_OE));
  localparam logic [ADDR_W-1:0] A_OE_CLR  = ADDR_W'(clr_addr(GRP_OE));
  localparam logic [ADDR_W-1:0] A_OE_STAT = ADDR_W'(stat_addr(GRP_OE));

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R7
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  // R2
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OE_SET) |=>
      ((oe_q & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((oe_q & ~$past(bus_wdata)) == ($past(oe_q) & ~$past(bus_wdata))));

  // R3
  oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OE_CLR) |=>
      ((oe_q & $past(bus_wdata)) == '0) &&
      ((oe_q & ~$past(bus_wdata)) == ($past(oe_q) & ~$past(bus_wdata))));

  // R6
  od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_q) == '0);

  // R9
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OE_STAT) |=> $stable(oe_q) && $stable(own_q));

  // R8
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (pin_data == $past(pad_in, 2)));
endmodule

bind pin_ctrl_bank pin_ctrl_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_in    (pad_in),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .pad_out   (pad_out),
  .oe_q      (oe_q),
  .own_q     (own_q),
  .od_q      (od_q),
  .pin_data  (pin_data)
);

// File: tb/pin_ctrl_bank_bench.sv
`timescale 1ns/1ps
module pin_ctrl_bank_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  fn_oe_v [4];
  logic [N-1:0]  fn_out_v [4];
  logic [4*N-1:0] fn_oe, fn_out;
  logic [N-1:0]  pad_oe, pad_out, pad_pu, pad_pd, pad_schmitt_dis;
  logic [2*N-1:0] periph_sel;

  assign fn_oe  = {fn_oe_v[3], fn_oe_v[2], fn_oe_v[1], fn_oe_v[0]};
  assign fn_out = {fn_out_v[3], fn_out_v[2], fn_out_v[1], fn_out_v[0]};

  always #2.5 clk = ~clk;

  pin_ctrl_bank u_pin_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .fn_oe(fn_oe), .fn_out(fn_out), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_schmitt_dis(pad_schmitt_dis),
    .periph_sel(periph_sel)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // reference state: groups 0 own,1 oe,2 out,3 pu,4 pd,5 od
  logic [N-1:0] m_ctl [6];
  logic [N-1:0] m_lo, m_hi, m_schm;
  logic [N-1:0] hist [$];

  task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl[0] = '1; m_ctl[1] = '0; m_ctl[2] = '0;
    m_ctl[3] = '1; m_ctl[4] = '0; m_ctl[5] = '0;
    m_lo = '0; m_hi = '0; m_schm = '0;
  endtask

  task automatic model_write(int a, logic [N-1:0] d);
    int g;
    int k;
    g = a / 3;
    k = a % 3;
    if (g < 6) begin
      if (k == 0) begin
        m_ctl[g] = m_ctl[g] | d;
        if (g == 3) m_ctl[4] = m_ctl[4] & ~d;
        if (g == 4) m_ctl[3] = m_ctl[3] & ~d;
      end else if (k == 1) begin
        m_ctl[g] = m_ctl[g] & ~d;
      end
    end else if (a == 18) m_lo = d;
    else if (a == 19) m_hi = d;
    else if (a == 20) m_schm = d;
  endtask

  function automatic logic [N-1:0] exp_read(int a);
    if (a < 18 && a % 3 == 2) return m_ctl[a / 3];
    if (a == 18) return m_lo;
    if (a == 19) return m_hi;
    if (a == 20) return m_schm;
    if (a == 21) return (hist.size() >= 2) ? hist[hist.size() - 2] : '0;
    return '0;
  endfunction

  always @(posedge clk) begin
    hist.push_back(rst_n ? pad_in : '0);
    if (hist.size() > 4) void'(hist.pop_front());
  end

  // every-cycle comparison of the pad side
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [N-1:0] eoe, eout, slo, shi;
      for (int i = 0; i < N; i++) begin
        int f;
        logic o, v;
        f = int'({m_hi[i], m_lo[i]});
        if (m_ctl[0][i]) begin o = m_ctl[1][i]; v = m_ctl[2][i]; end
        else begin o = fn_oe_v[f][i]; v = fn_out_v[f][i]; end
        if (m_ctl[5][i]) begin eoe[i] = o & ~v; eout[i] = 1'b0; end
        else begin eoe[i] = o; eout[i] = v; end
        slo[i] = periph_sel[2*i];
        shi[i] = periph_sel[2*i+1];
      end
      chk("R5/R6", "pad_oe", pad_oe, eoe);
      chk("R5/R6", "pad_out", pad_out, eout);
      chk("R7", "pad_pu", pad_pu, m_ctl[3]);
      chk("R7", "pad_pd", pad_pd, m_ctl[4]);
      chk("R10", "pad_schmitt_dis", pad_schmitt_dis, m_schm);
      chk("R4", "periph_sel low bits", slo, m_lo);
      chk("R4", "periph_sel high bits", shi, m_hi);
    end
  end

  task automatic wr(int a, logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(posedge clk);
    #1 model_write(a, d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    bus_addr = 5'(a);
    #1 chk(tag, $sformatf("read addr %0d", a), bus_rdata, exp_read(a));
  endtask

  task automatic rd_all(string tag);
    for (int g = 0; g < 6; g++) rd(3 * g + 2, tag);
    rd(18, tag); rd(19, tag); rd(20, tag);
  endtask

  initial begin
    fn_oe_v[0] = 32'h0000_FF00; fn_out_v[0] = 32'h0000_F0F0;
    fn_oe_v[1] = 32'h0000_0F00; fn_out_v[1] = 32'h0000_3C00;
    fn_oe_v[2] = 32'h0000_F000; fn_out_v[2] = 32'h0000_AA00;
    fn_oe_v[3] = 32'h0000_3300; fn_out_v[3] = 32'h0000_5500;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    rd_all("R1");
    rd(21, "R1");

    // R2: set with zeros leaving bits alone
    wr(3, 32'h0000_00F0); rd(5, "R2");
    wr(3, 32'h0000_0001); rd(5, "R2");
    wr(6, 32'h0000_0051); rd(8, "R2");
    wr(15, 32'h8000_0000); rd(17, "R2");
    // R3
    wr(4, 32'h0000_0030); rd(5, "R3");
    wr(7, 32'h0000_0010); rd(8, "R3");
    wr(16, 32'h8000_0000); rd(17, "R3");

    // R4/R5: pins 8..15 to peripherals, all four codes used
    wr(1, 32'h0000_FF00); rd(2, "R3");
    wr(18, 32'h0000_AA00); wr(19, 32'h0000_CC00);
    rd(18, "R4"); rd(19, "R4");
    repeat (2) @(negedge clk);
    fn_oe_v[1] = 32'h0000_FFFF; fn_out_v[3] = 32'h0000_FF00;
    repeat (2) @(negedge clk);

    // R6: open-drain on GPIO and peripheral pins
    wr(15, 32'h0000_FFF1); rd(17, "R6");
    wr(6, 32'h0000_00F1);
    repeat (2) @(negedge clk);
    wr(16, 32'h0000_00F0);

    // R7: pull exclusion both ways
    wr(12, 32'h0000_000F); rd(11, "R7"); rd(14, "R7");
    wr(9, 32'h0000_0003); rd(11, "R7"); rd(14, "R7");
    wr(13, 32'h0000_0004); rd(14, "R7");
    wr(10, 32'hFFFF_0000); rd(11, "R7");

    // R9: status and pin-data writes ignored
    for (int g = 0; g < 6; g++) wr(3 * g + 2, 32'hFFFF_FFFF);
    wr(5, 32'h0000_0000); wr(21, 32'h1234_5678);
    rd_all("R9");

    // R10
    wr(20, 32'h8000_8001); rd(20, "R10");
    wr(0, 32'h0000_0F00); rd(2, "R2");

    // R8: latency from pad_in to data register
    @(negedge clk);
    pad_in = 32'hA5A5_0F0F;
    rd(21, "R8");
    @(negedge clk); rd(21, "R8");
    @(negedge clk); rd(21, "R8");
    chk("R8", "pin data after two edges", bus_rdata, 32'hA5A5_0F0F);
    pad_in = 32'h0000_FF00;
    @(negedge clk); rd(21, "R8");
    chk("R8", "pin data after one edge", bus_rdata, 32'hA5A5_0F0F);
    @(negedge clk); rd(21, "R8");
    chk("R8", "pin data incl. peripheral pins", bus_rdata, 32'h0000_FF00);

    repeat (2) @(negedge clk);
    cmp_en = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule